// File: doc/BRIEF.md
# Block-Frame Serial Transmitter with Manchester Line Coding

This block builds one outgoing frame when a start strobe arrives and shifts it out on a single Manchester-coded line. On the strobe it latches a 4-bit block count and fifteen 128-bit data blocks, all in the same clock cycle. The frame begins with an opening flag and a fixed 16-bit header word. The selected number of blocks follows, each made of 128 data bits and then a 16-bit check word for that block. A closing flag ends the frame.

Between the two flags a zero is inserted after every run of five ones, so that the payload can never look like a flag. Each transmitted bit takes two half-periods of a parameterised number of clock cycles, and the line rests low between frames. A busy output covers the whole frame, and any strobe that arrives while it is high is dropped. The upstream logic normally issues strobes on a fixed interval and must pick the divider so that one frame fits within that interval.

Top module: `hdlc_blk_tx`

## Requirements
- R1: Count and block data are latched in the cycle where `start_i` is sampled high while idle; changing those inputs later has no effect on the frame in progress.
- R2: `busy_o` goes high on the clock edge that accepts the strobe and stays high until the closing flag's last bit has been sent; a strobe seen while busy is ignored and starts no second frame.
- R3: The frame on the line is the flag 0x7E, the header 0x0564, the blocks, and the flag 0x7E, every field sent most significant bit first.
- R4: A count of 1 to 15 sends that many blocks; a count of 0 sends exactly one block.
- R5: Block k (k = 0 to 14) is taken from `blk_data_i[128*k+127 : 128*k]` and sent from bit 127 down to bit 0, so its first 16-bit word is bits 127:112.
- R6: Each block's check word is a CRC-16 with polynomial 0x3D65, seeded with 0 at the start of the block and fed the block's 128 data bits MSB first. The result is inverted bitwise and sent MSB first.
- R7: Within header, data and check fields, a 0 is inserted after every five consecutive ones. The run count carries across field and block borders, and a run of five that ends the last check word is followed by a stuffed 0 before the closing flag. The flags themselves are never stuffed.
- R8: Every bit occupies two halves of `CLK_DIV` clock cycles each: a 1 is sent as low then high, a 0 as high then low.
- R9: Whenever no frame is in progress, `ser_o` is held low.
- R10: Right after reset, `busy_o` and `ser_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Frame start strobe |
| blk_cnt_i | input | 4 | Number of blocks to send (0 acts as 1) |
| blk_data_i | input | 1920 | Fifteen 128-bit blocks, block k at bits 128*k+127 down to 128*k |
| busy_o | output | 1 | High while a frame is being sent |
| ser_o | output | 1 | Manchester-coded serial line |

## Verification
Most internal faults show up as a wrong decoded bit on the line. A stale check-word register, a block pointer that is off by one, or a bad stuffing count corrupts the first affected bit within one bit period, that is within 2*`CLK_DIV` cycles of where the error starts. A bad field or block counter changes the frame length, so the line or `busy_o` is still active, or already idle, when the closing flag is due. A broken divider or phase register shows up in the very first bit as an unequal pair of half-periods. The bench decodes every half-period and compares the whole stream against a model of the frame, so the first differing bit is reported.

// File: rtl/hdlc_tx_pkg.sv
// Shared constants and types for the block-frame serial transmitter.
// Assumes fixed 128-bit blocks and 16-bit header and check words.
package hdlc_tx_pkg;
    localparam int          BLK_BITS  = 128;
    localparam logic [7:0]  FLAG_BYTE = 8'h7E;
    localparam logic [15:0] HDR_WORD  = 16'h0564;
    localparam logic [15:0] CRC_POLY  = 16'h3D65;

    typedef enum logic [2:0] {
        S_IDLE, S_OPEN, S_HDR, S_DATA, S_CRC, S_CLOSE, S_DONE
    } tx_state_t;
endpackage

// File: rtl/hdlc_tx_tick.sv
// Half-bit timing: counts CLK_DIV cycles per half-period while run is high.
// Emits the current half (phase) and a strobe at the end of each full bit.
// Assumes CLK_DIV >= 1; counter and phase rest at zero while run is low.
module hdlc_tx_tick #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase,
    output logic bit_end
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [DW-1:0] div_cnt;
    logic          half_end;

    assign half_end = run && (div_cnt == DW'(CLK_DIV - 1));
    assign bit_end  = half_end && phase;

    // Advance the divider and flip the half at each half-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            phase   <= 1'b0;
        end else if (half_end) begin
            div_cnt <= '0;
            phase   <= ~phase;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assert_div_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(div_cnt) < CLK_DIV)
        else $error("divider left its range");
endmodule

// File: rtl/hdlc_tx_crc.sv
// Serial CRC-16 register, MSB-first, polynomial from the package.
// A clear takes priority over a step; the output is the raw remainder.
module hdlc_tx_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        step,
    input  logic        din,
    output logic [15:0] crc
);
    import hdlc_tx_pkg::*;

    logic fb;
    assign fb = crc[15] ^ din;

    // Seed on clear, else shift one data bit through the divider.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc <= '0;
        else if (step)
            crc <= {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end

    assert_crc_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) && !clr && !step |-> crc == 16'h0000)
        else $error("check word not seeded");
endmodule

// File: rtl/hdlc_tx_manch.sv
// Manchester line coder: a 1 is low-then-high, a 0 is high-then-low.
// Registers the line so it is glitch free; the line is low while run is low.
module hdlc_tx_manch (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic phase,
    input  logic bit_in,
    output logic line
);
    // Drive the half-period level for the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            line <= 1'b0;
        else
            line <= phase ? bit_in : ~bit_in;
    end
endmodule

// File: rtl/hdlc_blk_tx.sv
// Block-frame transmitter top: latches count and blocks on a start strobe,
// then sequences flag, header, blocks with check words and closing flag,
// applying zero insertion between the flags. Assumes the strobe is ignored
// while busy. The data shift register has no reset; it is loaded before use.
module hdlc_blk_tx #(
    parameter int CLK_DIV = 2,
    parameter int CNT_W   = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [CNT_W-1:0]                    blk_cnt_i,
    input  logic [((1<<CNT_W)-1)*128-1:0]       blk_data_i,
    output logic                                busy_o,
    output logic                                ser_o
);
    import hdlc_tx_pkg::*;

    localparam int MAX_BLK = (1 << CNT_W) - 1;
    localparam int TOT     = MAX_BLK * BLK_BITS;
    localparam int CW      = $clog2(BLK_BITS);

    tx_state_t        state;
    logic [CW-1:0]    cnt;
    logic [CNT_W-1:0] blk_left;
    logic [2:0]       ones;
    logic [TOT-1:0]   shreg;
    logic             cur_bit, tx_on, phase, bit_end;
    logic             load, stuff, accept, raw_bit, field_end;
    logic [15:0]      crc;

    assign accept = (state == S_IDLE) && start_i;
    assign load   = (state != S_IDLE) && (!tx_on || bit_end);
    assign stuff  = (ones == 3'd5);
    assign busy_o = (state != S_IDLE);

    // Pick the next unstuffed bit and detect the last bit of each field.
    always_comb begin
        raw_bit   = 1'b0;
        field_end = 1'b0;
        case (state)
            S_OPEN, S_CLOSE: begin
                raw_bit   = FLAG_BYTE[~cnt[2:0]];
                field_end = (cnt == CW'(7));
            end
            S_HDR: begin
                raw_bit   = HDR_WORD[~cnt[3:0]];
                field_end = (cnt == CW'(15));
            end
            S_DATA: begin
                raw_bit   = shreg[TOT-1];
                field_end = (cnt == CW'(BLK_BITS - 1));
            end
            S_CRC: begin
                raw_bit   = ~crc[~cnt[3:0]];
                field_end = (cnt == CW'(15));
            end
            default: ;
        endcase
    end

    // Latch all blocks with block 0 at the top, then shift one data bit per use.
    for (genvar b = 0; b < MAX_BLK; b++) begin : g_cap
        always_ff @(posedge clk) begin
            if (accept)
                shreg[(MAX_BLK-1-b)*BLK_BITS +: BLK_BITS] <= blk_data_i[b*BLK_BITS +: BLK_BITS];
            else if (load && !stuff && state == S_DATA)
                shreg[(MAX_BLK-1-b)*BLK_BITS +: BLK_BITS] <=
                    (b == MAX_BLK - 1) ? {shreg[BLK_BITS-2:0], 1'b0}
                    : {shreg[(MAX_BLK-1-b)*BLK_BITS +: BLK_BITS-1],
                       shreg[(MAX_BLK-1-b)*BLK_BITS - 1]};
        end
    end

    // Frame sequencer: field state, bit index, blocks left and ones run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            blk_left <= '0;
            ones     <= '0;
            cur_bit  <= 1'b0;
            tx_on    <= 1'b0;
        end else if (accept) begin
            state    <= S_OPEN;
            cnt      <= '0;
            ones     <= '0;
            tx_on    <= 1'b0;
            blk_left <= (blk_cnt_i == '0) ? '0 : blk_cnt_i - 1'b1;
        end else if (load) begin
            tx_on <= 1'b1;
            if (state == S_DONE) begin
                state <= S_IDLE;
                tx_on <= 1'b0;
            end else if (stuff) begin
                cur_bit <= 1'b0;
                ones    <= '0;
            end else begin
                cur_bit <= raw_bit;
                if (state == S_OPEN || state == S_CLOSE)
                    ones <= '0;
                else
                    ones <= raw_bit ? ones + 1'b1 : '0;
                cnt <= field_end ? '0 : cnt + 1'b1;
                if (field_end) begin
                    case (state)
                        S_OPEN:  state <= S_HDR;
                        S_HDR:   state <= S_DATA;
                        S_DATA:  state <= S_CRC;
                        S_CRC: begin
                            if (blk_left == '0) state <= S_CLOSE;
                            else begin
                                state    <= S_DATA;
                                blk_left <= blk_left - 1'b1;
                            end
                        end
                        default: state <= S_DONE;
                    endcase
                end
            end
        end
    end

    hdlc_tx_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(tx_on), .phase(phase), .bit_end(bit_end)
    );

    hdlc_tx_crc u_crc (
        .clk(clk), .rst_n(rst_n),
        .clr(accept || (load && !stuff && state == S_CRC && field_end)),
        .step(load && !stuff && state == S_DATA),
        .din(shreg[TOT-1]), .crc(crc)
    );

    hdlc_tx_manch u_manch (
        .clk(clk), .rst_n(rst_n), .run(tx_on), .phase(phase),
        .bit_in(cur_bit), .line(ser_o)
    );

    assert_ones_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= 3'd5)
        else $error("ones run exceeded five");

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i))
        else $error("busy rose without a strobe");

    assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && $past(!busy_o) |-> !ser_o)
        else $error("line active while idle");

    assert_no_stuff_in_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_OPEN |-> ones == 3'd0)
        else $error("run count nonzero in opening flag");
endmodule

// File: tb/hdlc_blk_tx_tb.sv
// Bench: random and directed frames, decoded from the line and compared
// against a model of flag, header, blocks, check words and zero insertion.
module hdlc_blk_tx_tb;
    localparam int CLK_DIV = 2;
    localparam int NB      = 15;
    localparam int DW      = NB * 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [3:0]    blk_cnt_i = '0;
    logic [DW-1:0] blk_data_i = '0;
    logic          busy_o, ser_o;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_q[$];

    always #5 clk = ~clk;

    hdlc_blk_tx #(.CLK_DIV(CLK_DIV), .CNT_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_cnt_i(blk_cnt_i),
        .blk_data_i(blk_data_i), .busy_o(busy_o), .ser_o(ser_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input logic [127:0] d);
        logic [15:0] c = '0;
        for (int i = 127; i >= 0; i--) begin
            logic fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h3D65 : 16'h0000);
        end
        return c;
    endfunction

    // Model of the frame as a bit stream on the line.
    task automatic build_exp(input logic [3:0] cnt, input logic [DW-1:0] d);
        bit body[$];
        int nb = (cnt == 0) ? 1 : int'(cnt);
        int ones = 0;
        exp_q.delete();
        for (int i = 15; i >= 0; i--) body.push_back(bit'(16'h0564 >> i));
        for (int k = 0; k < nb; k++) begin
            logic [127:0] blk = d[k*128 +: 128];
            logic [15:0]  c   = ~crc_of(blk);
            for (int i = 127; i >= 0; i--) body.push_back(blk[i]);
            for (int i = 15; i >= 0; i--) body.push_back(c[i]);
        end
        for (int i = 7; i >= 0; i--) exp_q.push_back(bit'(8'h7E >> i));
        foreach (body[i]) begin
            exp_q.push_back(body[i]);
            ones = body[i] ? ones + 1 : 0;
            if (ones == 5) begin
                exp_q.push_back(1'b0);
                ones = 0;
            end
        end
        for (int i = 7; i >= 0; i--) exp_q.push_back(bit'(8'h7E >> i));
    endtask

    function automatic logic [DW-1:0] rand_data();
        logic [DW-1:0] v;
        for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    // Send one frame and decode it; optionally strobe again mid-frame.
    task automatic run_frame(input logic [3:0] cnt, input logic [DW-1:0] d,
                             input bit poke, input string tag);
        int  nbits, bad_bits, bad_man, bad_busy, first_bad, hdr_bad;
        bit  h0, h1;
        build_exp(cnt, d);
        nbits = exp_q.size();
        bad_bits = 0; bad_man = 0; bad_busy = 0; first_bad = -1; hdr_bad = 0;
        @(negedge clk);
        blk_cnt_i  = cnt;
        blk_data_i = d;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        chk(busy_o == 1'b1, "R2", {tag, " busy after strobe"}, busy_o, 1);
        blk_cnt_i  = 4'($urandom());
        blk_data_i = rand_data();           // R1: late changes must not matter
        @(posedge ser_o);
        #(5 + 10 * (CLK_DIV / 2));
        for (int b = 0; b < nbits; b++) begin
            h0 = ser_o;
            if (busy_o !== 1'b1) bad_busy++;
            if (poke && b == 40) start_i = 1'b1;
            #(10 * CLK_DIV);
            start_i = 1'b0;
            h1 = ser_o;
            if (b != nbits - 1 && busy_o !== 1'b1) bad_busy++;
            if (h0 == h1) bad_man++;
            if (h1 != exp_q[b]) begin
                bad_bits++;
                if (first_bad < 0) first_bad = b;
                if (b < 24) hdr_bad++;
            end
            #(10 * CLK_DIV);
        end
        chk(bad_man == 0, "R8", {tag, " half-period pairs"}, bad_man, 0);
        chk(hdr_bad == 0, "R3", {tag, " flag and header"}, hdr_bad, 0);
        chk(bad_bits == 0, "R1 R5 R6 R7", {tag, " stream bits (first bad index)"},
            first_bad, -1);
        chk(bad_busy == 0, "R2", {tag, " busy during frame"}, bad_busy, 0);
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0, "R2", {tag, " busy after frame"}, busy_o, 0);
        chk(ser_o == 1'b0, "R9", {tag, " line after frame"}, ser_o, 0);
        if (poke) begin
            int act = 0;
            repeat (60) begin
                @(negedge clk);
                if (busy_o || ser_o) act++;
            end
            chk(act == 0, "R2", {tag, " strobe while busy ignored"}, act, 0);
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected frame completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R10", "busy in reset", busy_o, 0);
        chk(ser_o == 1'b0, "R10", "line in reset", ser_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && ser_o == 1'b0, "R10", "idle after reset",
            {busy_o, ser_o}, 0);

        run_frame(4'd1, '0, 1'b0, "R4 one zero block");
        run_frame(4'd0, rand_data(), 1'b0, "R4 count zero as one");
        run_frame(4'd15, '1, 1'b0, "R7 fifteen all-ones blocks");
        run_frame(4'd3, rand_data(), 1'b1, "R2 strobe mid-frame");
        for (int i = 0; i < 4; i++)
            run_frame(4'($urandom_range(1, 15)), rand_data(), 1'(i & 1), "random");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule